// File: doc/BRIEF.md
# Clock Stop Detection Monitor

This block runs on a free-running internal RC reference clock and watches two external clocks, a main clock and a sub clock. Each observed clock is brought into the RC domain through a synchronizer, and its rising edges restart a per-clock window. The window is made from coarse prescaler ticks. If the window runs out with no rising edge, a sticky missing flag is set for that clock. Software clears both flags by reading the status register. That read shows up here as a one-cycle strobe.

A monitor works only while the RC clock is marked running and at least one of that clock's two qualifiers is 1: its oscillator enable bit or its monitor bit. One interval select input picks a long window or a short window. When a clock is found missing while it drives either system clock select or the watchdog, the block sends out a one-cycle clock-failure reset request. All pins are plain control and status levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `clk_stop_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, both missing flags and the reset request are 0.
- R2: With `win_short_i` = 0, a monitor flags its clock no sooner than 388 and no later than 515 RC cycles after the last rising edge of that clock. This is 3 to 4 ticks of 128 RC cycles, plus the synchronizer latency.
- R3: With `win_short_i` = 1, the window is 3 to 4 ticks of 8 RC cycles. The flag rises 28 to 35 RC cycles after the last rising edge, so a clock with a 40-cycle period is flagged in this mode.
- R4: Each synchronized rising edge restarts the window. A clock whose period is well inside the window never sets its flag.
- R5: A monitor is active only while `rc_running_i` = 1 and its enable or monitor bit is 1. While it is inactive its window is held at its start and its flag is never set.
- R6: The main and sub monitors are independent. `main_missing_o` reflects only the main clock and `sub_missing_o` only the sub clock.
- R7: A cycle with `stat_rd_i` = 1 clears both flags on the next RC edge. A detection in the same cycle as the read wins, and that flag stays 1.
- R8: Source selects use the code 2'b01 for the main clock and 2'b10 for the sub clock; 2'b00 and 2'b11 name other sources. `fail_rst_req_o` pulses high for exactly one cycle, the cycle in which a flag goes from 0 to 1. It pulses only if that clock's code is on `sys_src_a_i`, `sys_src_b_i` or `wdt_src_i` in the detecting cycle.
- R9: While a flag stays set, a continued absence re-detects every window but gives no further reset request. After the flag is cleared, the next detection pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_running_i | input | 1 | RC clock is running; qualifies both monitors |
| main_clk_i | input | 1 | Observed main clock (asynchronous) |
| sub_clk_i | input | 1 | Observed sub clock (asynchronous) |
| main_en_i | input | 1 | Main oscillator enable bit |
| main_mon_i | input | 1 | Main oscillator monitor bit |
| sub_en_i | input | 1 | Sub oscillator enable bit |
| sub_mon_i | input | 1 | Sub oscillator monitor bit |
| win_short_i | input | 1 | Interval select: 0 long window, 1 short window |
| sys_src_a_i | input | 2 | Source code of the first system clock select |
| sys_src_b_i | input | 2 | Source code of the second system clock select |
| wdt_src_i | input | 2 | Source code of the watchdog clock |
| stat_rd_i | input | 1 | One-cycle strobe for a status register read |
| main_missing_o | output | 1 | Sticky main clock missing flag |
| sub_missing_o | output | 1 | Sticky sub clock missing flag |
| fail_rst_req_o | output | 1 | One-cycle clock-failure reset request |

## Verification
The patterns are:
- Both clocks toggle well inside the long window, which separates a monitor that restarts on each edge from one that merely counts time.
- The main clock stops while selected as a system clock. This measures the latency against the 3-to-4-tick bounds of each window and shows that a stuck absence re-detects without a second request.
- In the short window, the sub clock's 40-cycle period is too slow, which shows both the window scaling and the independence of the two flags.
- The enable and monitor bits and the RC-running input are cleared one at a time. A read strobe is held across detections to show that a set beats a clear.
- The watchdog select points at the sub clock, to show that a request follows whichever select names the failed clock.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [1:0] {
    SRC_ALT0 = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10,
    SRC_ALT3 = 2'b11
  } clk_src_e;

  localparam int unsigned NUM_MON  = 2;
  localparam int unsigned MON_MAIN = 0;
  localparam int unsigned MON_SUB  = 1;

  function automatic clk_src_e mon_src(input int unsigned idx);
    return (idx == MON_MAIN) ? SRC_MAIN : SRC_SUB;
  endfunction

  function automatic logic src_hits(input logic [1:0] sel, input clk_src_e want);
    return (sel == want);
  endfunction

endpackage

// File: rtl/csd_prescaler.sv
module csd_prescaler #(
  parameter int unsigned SLOW_DIV = 128,
  parameter int unsigned FAST_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_sel,
  output logic tick
);
  localparam int unsigned SW = $clog2(SLOW_DIV);
  localparam int unsigned FW = $clog2(FAST_DIV);

  logic [SW-1:0] cnt_q;
  logic          slow_tick;
  logic          fast_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign slow_tick = (cnt_q == {SW{1'b1}});
  assign fast_tick = (cnt_q[FW-1:0] == {FW{1'b1}});

  always_comb begin
    tick = short_sel ? fast_tick : slow_tick;
  end

  assert_fast_ticks_dense_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |-> fast_tick);

endmodule

// File: rtl/csd_sync_edge.sv
module csd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-1:0], async_in};
  end

  assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/csd_window_mon.sv
module csd_window_mon #(
  parameter int unsigned TRIP_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rise,
  input  logic tick,
  input  logic rd,
  input  logic in_use,
  output logic flag_o,
  output logic req_o
);
  localparam int unsigned TW = $clog2(TRIP_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(TRIP_TICKS - 1);

  logic [TW-1:0] tcnt_q;
  logic          flag_q;
  logic          req_q;
  logic          detect;

  assign detect = active && !rise && tick && (tcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (!active || rise) begin
      tcnt_q <= '0;
    end else if (tick) begin
      tcnt_q <= (tcnt_q == LAST) ? '0 : tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= detect && !flag_q && in_use;
      if (detect)  flag_q <= 1'b1;
      else if (rd) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = req_q;

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (tcnt_q == '0));
  assert_no_set_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !flag_q) |=> !flag_q);
  assert_edge_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rise) |=> (tcnt_q == '0));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !active) |=> !flag_q);
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && rd) |=> flag_q);
  assert_req_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (flag_q && $past(in_use)));
  assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

endmodule

// File: rtl/clk_stop_monitor.sv
module clk_stop_monitor #(
  parameter int unsigned SLOW_DIV    = 128,
  parameter int unsigned FAST_DIV    = 8,
  parameter int unsigned TRIP_TICKS  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       rc_clk,
  input  logic       rst_n,
  input  logic       rc_running_i,
  input  logic       main_clk_i,
  input  logic       sub_clk_i,
  input  logic       main_en_i,
  input  logic       main_mon_i,
  input  logic       sub_en_i,
  input  logic       sub_mon_i,
  input  logic       win_short_i,
  input  logic [1:0] sys_src_a_i,
  input  logic [1:0] sys_src_b_i,
  input  logic [1:0] wdt_src_i,
  input  logic       stat_rd_i,
  output logic       main_missing_o,
  output logic       sub_missing_o,
  output logic       fail_rst_req_o
);
  import csd_pkg::*;

  logic                tick;
  logic [NUM_MON-1:0]  obs;
  logic [NUM_MON-1:0]  qual;
  logic [NUM_MON-1:0]  active;
  logic [NUM_MON-1:0]  rise;
  logic [NUM_MON-1:0]  in_use;
  logic [NUM_MON-1:0]  flag;
  logic [NUM_MON-1:0]  req;

  assign obs  = {sub_clk_i, main_clk_i};
  assign qual = {sub_en_i | sub_mon_i, main_en_i | main_mon_i};

  csd_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
    .clk(rc_clk), .rst_n(rst_n), .short_sel(win_short_i), .tick(tick)
  );

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    assign active[g] = rc_running_i & qual[g];
    assign in_use[g] = src_hits(sys_src_a_i, mon_src(g)) |
                       src_hits(sys_src_b_i, mon_src(g)) |
                       src_hits(wdt_src_i,   mon_src(g));

    csd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(rc_clk), .rst_n(rst_n), .async_in(obs[g]), .rise(rise[g])
    );

    csd_window_mon #(.TRIP_TICKS(TRIP_TICKS)) u_win (
      .clk(rc_clk), .rst_n(rst_n), .active(active[g]), .rise(rise[g]),
      .tick(tick), .rd(stat_rd_i), .in_use(in_use[g]),
      .flag_o(flag[g]), .req_o(req[g])
    );
  end

  assign main_missing_o = flag[MON_MAIN];
  assign sub_missing_o  = flag[MON_SUB];
  assign fail_rst_req_o = |req;

  assert_reset_quiet_R1: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!main_missing_o && !sub_missing_o && !fail_rst_req_o));
  assert_req_needs_flag_R8: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fail_rst_req_o |-> (main_missing_o || sub_missing_o));

endmodule

// File: tb/clk_stop_monitor_tb.sv
module clk_stop_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rc_run = 1'b0;
  logic [1:0] obs_v = 2'b00;
  logic [1:0] en_v = 2'b00;
  logic [1:0] mon_v = 2'b00;
  logic win = 1'b0;
  logic [1:0] sa = 2'b00, sb = 2'b00, wd = 2'b00;
  logic rd = 1'b0;
  logic main_flag, sub_flag, req;

  int checks = 0, fails = 0, cyc = 0, pulses = 0;
  int half[2] = '{5, 20};
  int hcnt[2] = '{0, 0};
  bit run[2] = '{1'b1, 1'b1};
  int last_rise[2] = '{0, 0};
  int lat[2] = '{-1, -1};
  bit prev_f[2] = '{1'b0, 1'b0};

  always #2.5 clk = ~clk;

  clk_stop_monitor u_dut (
    .rc_clk(clk), .rst_n(rst_n), .rc_running_i(rc_run),
    .main_clk_i(obs_v[0]), .sub_clk_i(obs_v[1]),
    .main_en_i(en_v[0]), .main_mon_i(mon_v[0]),
    .sub_en_i(en_v[1]), .sub_mon_i(mon_v[1]),
    .win_short_i(win), .sys_src_a_i(sa), .sys_src_b_i(sb), .wdt_src_i(wd),
    .stat_rd_i(rd), .main_missing_o(main_flag), .sub_missing_o(sub_flag),
    .fail_rst_req_o(req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference model: behavioural, one update per RC edge
  int pc = 0;
  bit s0[2], s1[2], s2[2];
  int tk[2];
  bit mf[2], mr[2];
  bit m_tick, m_act, m_edge, m_det, m_use;
  logic [1:0] code;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      pc = 0;
      for (int i = 0; i < 2; i++) begin
        s0[i] = 0; s1[i] = 0; s2[i] = 0; tk[i] = 0; mf[i] = 0; mr[i] = 0;
      end
    end else begin
      m_tick = win ? (pc % 8 == 7) : (pc % 128 == 127);
      for (int i = 0; i < 2; i++) begin
        code   = (i == 0) ? 2'b01 : 2'b10;
        m_use  = (sa == code) || (sb == code) || (wd == code);
        m_act  = rc_run && (en_v[i] || mon_v[i]);
        m_edge = s1[i] && !s2[i];
        m_det  = m_act && !m_edge && m_tick && (tk[i] == 3);
        if (!m_act || m_edge) tk[i] = 0;
        else if (m_tick) tk[i] = (tk[i] == 3) ? 0 : tk[i] + 1;
        mr[i] = m_det && !mf[i] && m_use;
        if (m_det) mf[i] = 1;
        else if (rd) mf[i] = 0;
        s2[i] = s1[i]; s1[i] = s0[i]; s0[i] = obs_v[i];
      end
      pc = (pc + 1) % 128;
    end
  end

  // per-cycle comparison, pulse count, latency capture, clock generation
  always @(negedge clk) begin
    chk(main_flag === mf[0], "R6 main flag vs model", int'(main_flag), int'(mf[0]));
    chk(sub_flag === mf[1], "R6 sub flag vs model", int'(sub_flag), int'(mf[1]));
    chk(req === (mr[0] | mr[1]), "R8 request vs model", int'(req), int'(mr[0] | mr[1]));
    if (req) pulses++;
    if (main_flag && !prev_f[0]) lat[0] = cyc - last_rise[0];
    if (sub_flag && !prev_f[1]) lat[1] = cyc - last_rise[1];
    prev_f[0] = main_flag; prev_f[1] = sub_flag;
    for (int i = 0; i < 2; i++) begin
      if (run[i]) begin
        hcnt[i]++;
        if (hcnt[i] >= half[i]) begin
          hcnt[i] = 0;
          obs_v[i] = ~obs_v[i];
          if (obs_v[i]) last_rise[i] = cyc;
        end
      end else begin
        obs_v[i] = 1'b0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pulse();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic wait_main();
    for (int k = 0; k < 2000 && !main_flag; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p0;
    step(5);
    chk(!main_flag && !sub_flag && !req, "R1 reset state", int'({main_flag, sub_flag, req}), 0);
    @(negedge clk) begin rst_n = 1'b1; rc_run = 1'b1; en_v = 2'b11; sa = 2'b01; end
    step(1);
    chk(!main_flag && !sub_flag && !req, "R1 after release", int'({main_flag, sub_flag, req}), 0);

    step(1500);
    chk(!main_flag && !sub_flag, "R4 running clocks not flagged", int'({main_flag, sub_flag}), 0);

    p0 = pulses; lat[0] = -1;
    run[0] = 0;
    wait_main();
    step(2);
    chk(lat[0] >= 388 && lat[0] <= 515, "R2 long window latency", lat[0], 450);
    chk(pulses == p0 + 1, "R8 request on selected main", pulses - p0, 1);

    p0 = pulses;
    step(1200);
    chk(main_flag && pulses == p0, "R9 no repeat while set", pulses - p0, 0);
    read_pulse();
    chk(!main_flag, "R7 read clears flag", int'(main_flag), 0);
    wait_main();
    step(2);
    chk(pulses == p0 + 1, "R9 pulse after clear", pulses - p0, 1);

    run[0] = 1; win = 1'b1;
    step(40);
    read_pulse();
    p0 = pulses;
    step(200);
    chk(!main_flag, "R3 fast main clock kept", int'(main_flag), 0);
    chk(sub_flag, "R6 slow sub flagged short window", int'(sub_flag), 1);
    chk(pulses == p0, "R8 unselected sub no request", pulses - p0, 0);

    lat[0] = -1; run[0] = 0;
    wait_main();
    step(2);
    chk(lat[0] >= 28 && lat[0] <= 35, "R3 short window latency", lat[0], 32);
    chk(pulses == p0 + 1, "R8 request short window", pulses - p0, 1);

    en_v[0] = 1'b0; mon_v[0] = 1'b0;
    read_pulse();
    step(300);
    chk(!main_flag, "R5 disabled monitor silent", int'(main_flag), 0);
    mon_v[0] = 1'b1;
    wait_main();
    chk(main_flag, "R5 monitor bit alone enables", int'(main_flag), 1);
    rc_run = 1'b0;
    read_pulse();
    step(300);
    chk(!main_flag && !sub_flag, "R5 RC stopped silent", int'({main_flag, sub_flag}), 0);

    rc_run = 1'b1;
    begin
      bit seen = 0;
      @(negedge clk) rd = 1'b1;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (sub_flag) seen = 1;
      end
      rd = 1'b0;
      chk(seen, "R7 set wins over held read", int'(seen), 1);
    end

    sa = 2'b00; wd = 2'b10;
    read_pulse();
    p0 = pulses;
    step(100);
    chk(pulses >= p0 + 1, "R8 watchdog on sub", pulses - p0, 1);

    step(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule